// File: doc/BRIEF.md
# FP system register write controller

This block carries out the transfer of a core register value into one of the floating-point system registers. Each request arrives as a one-cycle valid pulse. It carries a condition-pass flag, a 4-bit register selector, the index of the source core register and the 32-bit value. The block also receives the current privilege level and the coarse access and trap controls. From these it decides whether the write takes effect, is dropped without a fault, raises an undefined-instruction fault or is trapped to the hypervisor. The outcome is reported as a one-hot response on the following clock edge, and any register update is made on that same edge.

The block holds two writable registers and drives both out for readback. The first is the status/control register. The second is the exception-control register, which contains the floating-point enable bit. The identification register can be selected, but it holds no state here. When a write uses a reserved selector, the result is fixed at build time: either a fault or a no-op.

Top module: `fpw_sysreg_write`

## Requirements
- R1: A synchronous reset clears the status register and the exception-control register to zero, and leaves all four response outputs low.
- R2: Each request gives exactly one response bit, high for one cycle on the clock edge that follows. When no request is made, no response bit is set and neither register changes.
- R3: A request with condPass low reports rspIgnored and changes neither register, whatever its other fields hold.
- R4: With condPass high, a source index of 15 reports rspUndef and changes nothing. This check takes priority over every selector rule.
- R5: The selector codes are 0000 for identification, 0001 for status and 1000 for exception-control. Every other code is reserved. A reserved code reports rspUndef when RSV_UNDEF is 1 and rspIgnored when RSV_UNDEF is 0. In both cases neither register changes.
- R6: A write to the identification or exception-control register at privilege level 0 (user) reports rspUndef and changes nothing.
- R7: Once the checks above pass, a request with hypTrap high reports rspHypTrap and changes nothing.
- R8: Once the checks above pass, a request with cpAccessOk low or secureAccessOk low reports rspUndef and changes nothing.
- R9: A status write while exception-control bit 30 (the enable bit) is low reports rspUndef and leaves the status register unchanged.
- R10: A status write that passes every check reports rspDone and loads srcData into the status register. This applies at any privilege level.
- R11: An exception-control write that passes every check reports rspDone and loads srcData, whatever the current enable bit is.
- R12: A privileged identification write that passes every check reports rspIgnored and changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | One-cycle request pulse |
| condPass | input | 1 | Condition of the operation passed |
| regSel | input | 4 | Destination register selector |
| srcIdx | input | 4 | Index of the source core register |
| srcData | input | 32 | Value to be written |
| privLevel | input | 2 | Current privilege level, 0 is user |
| cpAccessOk | input | 1 | Coprocessor access control permits the access |
| secureAccessOk | input | 1 | Secure-state access control permits the access |
| hypTrap | input | 1 | Hypervisor trap control is set |
| rspDone | output | 1 | Write performed |
| rspIgnored | output | 1 | Request dropped without fault |
| rspUndef | output | 1 | Undefined-instruction fault |
| rspHypTrap | output | 1 | Trapped to hypervisor |
| statusReg | output | 32 | Status/control register |
| excReg | output | 32 | Exception-control register |

## Verification
The bench targets the places where the rules collide. These include a status write with the enable bit off while the coarse controls allow access, and an exception-control write with the enable bit off. A design that applied the enable bit to the wrong register would fault the second case or pass the first. The bench also combines a source index of 15 with reserved selectors and with user level. It runs reserved codes against both settings of the build parameter, and it gives privileged identification writes data that would be visible if stored. Each of these shows up as a wrong response bit or as a register that changes. Random requests with every control mixed in check the order in which faults are prioritised.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  typedef enum logic [1:0] {
    OUT_DONE    = 2'd0,
    OUT_IGNORED = 2'd1,
    OUT_UNDEF   = 2'd2,
    OUT_HYPTRAP = 2'd3
  } outcome_e;

  typedef struct packed {
    logic loadStatus;
    logic loadExc;
  } dpStrobe_t;

  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_ID     = 4'b0000;
  localparam logic [SEL_W-1:0] SEL_STATUS = 4'b0001;
  localparam logic [SEL_W-1:0] SEL_EXC    = 4'b1000;
endpackage

// File: rtl/fpw_ctrl.sv
module fpw_ctrl
  import fpw_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int BAD_IDX     = 15,
  parameter bit RSV_UNDEF   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic             condPass,
  input  logic [SEL_W-1:0] regSel,
  input  logic [IDX_W-1:0] srcIdx,
  input  logic [1:0]       privLevel,
  input  logic             cpAccessOk,
  input  logic             secureAccessOk,
  input  logic             hypTrap,
  input  logic             fpEnable,
  output dpStrobe_t        strobe,
  output logic [3:0]       rspOneHot
);
  localparam logic [IDX_W-1:0] BadIdxVal = IDX_W'(BAD_IDX);

  logic selId, selStatus, selExc, selReserved, idxBad, userLevel;
  outcome_e rsvOutcome;
  outcome_e outcome;

  generate
    if (RSV_UNDEF) begin : g_rsvUndef
      assign rsvOutcome = OUT_UNDEF;
    end else begin : g_rsvNop
      assign rsvOutcome = OUT_IGNORED;
    end
  endgenerate

  always_comb begin
    selId       = (regSel == SEL_ID);
    selStatus   = (regSel == SEL_STATUS);
    selExc      = (regSel == SEL_EXC);
    selReserved = !(selId || selStatus || selExc);
    idxBad      = (srcIdx == BadIdxVal);
    userLevel   = (privLevel == 2'd0);
  end

  // Priority chain: condition, operand, selector, privilege, trap, enable
  always_comb begin
    if (!condPass)                        outcome = OUT_IGNORED;
    else if (idxBad)                      outcome = OUT_UNDEF;
    else if (selReserved)                 outcome = rsvOutcome;
    else if (!selStatus && userLevel)     outcome = OUT_UNDEF;
    else if (hypTrap)                     outcome = OUT_HYPTRAP;
    else if (!cpAccessOk || !secureAccessOk) outcome = OUT_UNDEF;
    else if (selStatus && !fpEnable)      outcome = OUT_UNDEF;
    else if (selId)                       outcome = OUT_IGNORED;
    else                                  outcome = OUT_DONE;
  end

  always_comb begin
    strobe.loadStatus = reqValid && (outcome == OUT_DONE) && selStatus;
    strobe.loadExc    = reqValid && (outcome == OUT_DONE) && selExc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspOneHot <= '0;
    end else if (reqValid) begin
      rspOneHot <= 4'(1) << outcome;
    end else begin
      rspOneHot <= '0;
    end
  end
endmodule

// File: rtl/fpw_dp.sv
module fpw_dp
  import fpw_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ENABLE_BIT = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] statusReg,
  output logic [DATA_W-1:0] excReg,
  output logic              fpEnable
);
  always_ff @(posedge clk) begin
    if (rst) begin
      statusReg <= '0;
      excReg    <= '0;
    end else begin
      if (strobe.loadStatus) statusReg <= srcData;
      if (strobe.loadExc)    excReg    <= srcData;
    end
  end

  assign fpEnable = excReg[ENABLE_BIT];
endmodule

// File: rtl/fpw_sysreg_write.sv
module fpw_sysreg_write
  import fpw_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 4,
  parameter int BAD_IDX    = 15,
  parameter int ENABLE_BIT = 30,
  parameter bit RSV_UNDEF  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              condPass,
  input  logic [3:0]        regSel,
  input  logic [IDX_W-1:0]  srcIdx,
  input  logic [DATA_W-1:0] srcData,
  input  logic [1:0]        privLevel,
  input  logic              cpAccessOk,
  input  logic              secureAccessOk,
  input  logic              hypTrap,
  output logic              rspDone,
  output logic              rspIgnored,
  output logic              rspUndef,
  output logic              rspHypTrap,
  output logic [DATA_W-1:0] statusReg,
  output logic [DATA_W-1:0] excReg
);
  dpStrobe_t  strobe;
  logic       fpEnable;
  logic [3:0] rspOneHot;

  fpw_ctrl #(
    .IDX_W(IDX_W), .BAD_IDX(BAD_IDX), .RSV_UNDEF(RSV_UNDEF)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .condPass(condPass),
    .regSel(regSel), .srcIdx(srcIdx), .privLevel(privLevel),
    .cpAccessOk(cpAccessOk), .secureAccessOk(secureAccessOk),
    .hypTrap(hypTrap), .fpEnable(fpEnable), .strobe(strobe),
    .rspOneHot(rspOneHot)
  );

  fpw_dp #(
    .DATA_W(DATA_W), .ENABLE_BIT(ENABLE_BIT)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .srcData(srcData),
    .statusReg(statusReg), .excReg(excReg), .fpEnable(fpEnable)
  );

  assign rspDone    = rspOneHot[OUT_DONE];
  assign rspIgnored = rspOneHot[OUT_IGNORED];
  assign rspUndef   = rspOneHot[OUT_UNDEF];
  assign rspHypTrap = rspOneHot[OUT_HYPTRAP];
endmodule

// File: rtl/fpw_sysreg_write_chk.sv
module fpw_sysreg_write_chk #(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4,
  parameter int BAD_IDX = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              condPass,
  input logic [3:0]        regSel,
  input logic [IDX_W-1:0]  srcIdx,
  input logic [DATA_W-1:0] srcData,
  input logic [1:0]        privLevel,
  input logic              rspDone,
  input logic              rspIgnored,
  input logic              rspUndef,
  input logic              rspHypTrap,
  input logic [DATA_W-1:0] statusReg,
  input logic [DATA_W-1:0] excReg
);
  logic [3:0] rsp;
  assign rsp = {rspHypTrap, rspUndef, rspIgnored, rspDone};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (statusReg == '0) && (excReg == '0) && (rsp == '0));

  p_one_response_r2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> $countones(rsp) == 1);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (rsp == '0) && $stable(statusReg) && $stable(excReg));

  p_cond_fail_r3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !condPass) |=> rspIgnored && $stable(statusReg) && $stable(excReg));

  p_bad_index_r4: assert property (@(posedge clk) disable iff (rst)
    (reqValid && condPass && srcIdx == IDX_W'(BAD_IDX)) |=> rspUndef);

  p_user_priv_r6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && condPass && srcIdx != IDX_W'(BAD_IDX) && privLevel == 2'd0 &&
     (regSel == 4'b0000 || regSel == 4'b1000)) |=> rspUndef && $stable(excReg));

  p_status_load_r10: assert property (@(posedge clk) disable iff (rst)
    (reqValid && regSel == 4'b0001) |=>
      (rspDone ? (statusReg == $past(srcData)) : $stable(statusReg)));

  p_id_no_change_r12: assert property (@(posedge clk) disable iff (rst)
    (reqValid && regSel == 4'b0000) |=> !rspDone && $stable(statusReg) && $stable(excReg));
endmodule

bind fpw_sysreg_write fpw_sysreg_write_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .BAD_IDX(BAD_IDX)
) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .condPass(condPass),
  .regSel(regSel), .srcIdx(srcIdx), .srcData(srcData), .privLevel(privLevel),
  .rspDone(rspDone), .rspIgnored(rspIgnored), .rspUndef(rspUndef),
  .rspHypTrap(rspHypTrap), .statusReg(statusReg), .excReg(excReg)
);

// File: tb/test_fpw_sysreg_write.sv
module test_fpw_sysreg_write;
  localparam int DW = 32;
  localparam int EN_BIT = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, condPass = 1'b0;
  logic [3:0] regSel = '0, srcIdx = '0;
  logic [DW-1:0] srcData = '0;
  logic [1:0] privLevel = '0;
  logic cpAccessOk = 1'b0, secureAccessOk = 1'b0, hypTrap = 1'b0;

  logic dDone, dIgn, dUnd, dHyp; logic [DW-1:0] dStat, dExc;
  logic nDone, nIgn, nUnd, nHyp; logic [DW-1:0] nStat, nExc;

  int checks = 0, fails = 0;
  bit finished = 0;

  // Model state: index 0 = fault variant, 1 = no-op variant
  logic [DW-1:0] mStat [2];
  logic [DW-1:0] mExc  [2];

  always #2 clk = ~clk;

  fpw_sysreg_write #(.RSV_UNDEF(1'b1)) i_fpw_sysreg_write (
    .clk(clk), .rst(rst), .reqValid(reqValid), .condPass(condPass),
    .regSel(regSel), .srcIdx(srcIdx), .srcData(srcData), .privLevel(privLevel),
    .cpAccessOk(cpAccessOk), .secureAccessOk(secureAccessOk), .hypTrap(hypTrap),
    .rspDone(dDone), .rspIgnored(dIgn), .rspUndef(dUnd), .rspHypTrap(dHyp),
    .statusReg(dStat), .excReg(dExc));

  fpw_sysreg_write #(.RSV_UNDEF(1'b0)) i_fpw_sysreg_write_nop (
    .clk(clk), .rst(rst), .reqValid(reqValid), .condPass(condPass),
    .regSel(regSel), .srcIdx(srcIdx), .srcData(srcData), .privLevel(privLevel),
    .cpAccessOk(cpAccessOk), .secureAccessOk(secureAccessOk), .hypTrap(hypTrap),
    .rspDone(nDone), .rspIgnored(nIgn), .rspUndef(nUnd), .rspHypTrap(nHyp),
    .statusReg(nStat), .excReg(nExc));

  // Response code: bit0 done, bit1 ignored, bit2 undef, bit3 hyp trap
  function automatic logic [3:0] expRsp(input bit rsvUndef, input logic [DW-1:0] exc);
    bit isId, isSt, isEx;
    isId = (regSel == 4'b0000); isSt = (regSel == 4'b0001); isEx = (regSel == 4'b1000);
    if (!condPass) return 4'b0010;                              // R3
    if (srcIdx == 4'd15) return 4'b0100;                        // R4
    if (!(isId || isSt || isEx)) return rsvUndef ? 4'b0100 : 4'b0010; // R5
    if (!isSt && privLevel == 2'd0) return 4'b0100;             // R6
    if (hypTrap) return 4'b1000;                                // R7
    if (!cpAccessOk || !secureAccessOk) return 4'b0100;         // R8
    if (isSt && !exc[EN_BIT]) return 4'b0100;                   // R9
    if (isId) return 4'b0010;                                   // R12
    return 4'b0001;                                             // R10 R11
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input string tag);
    logic [3:0] e0, e1;
    e0 = expRsp(1'b1, mExc[0]);
    e1 = expRsp(1'b0, mExc[1]);
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (e0 == 4'b0001 && regSel == 4'b0001) mStat[0] = srcData;
    if (e0 == 4'b0001 && regSel == 4'b1000) mExc[0]  = srcData;
    if (e1 == 4'b0001 && regSel == 4'b0001) mStat[1] = srcData;
    if (e1 == 4'b0001 && regSel == 4'b1000) mExc[1]  = srcData;
    check({tag, " rsp"},      32'({dHyp, dUnd, dIgn, dDone}), 32'(e0));
    check({tag, " stat"},     dStat, mStat[0]);
    check({tag, " exc"},      dExc,  mExc[0]);
    check({tag, " rsp-nop"},  32'({nHyp, nUnd, nIgn, nDone}), 32'(e1));
    check({tag, " stat-nop"}, nStat, mStat[1]);
    check({tag, " exc-nop"},  nExc,  mExc[1]);
  endtask

  task automatic setReq(input bit c, input logic [3:0] s, input logic [3:0] i,
                        input logic [DW-1:0] d, input logic [1:0] p,
                        input bit ca, input bit sa, input bit ht);
    condPass = c; regSel = s; srcIdx = i; srcData = d; privLevel = p;
    cpAccessOk = ca; secureAccessOk = sa; hypTrap = ht;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 2; k++) begin mStat[k] = '0; mExc[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 stat", dStat, '0);
    check("R1 exc", dExc, '0);
    check("R1 rsp", 32'({dHyp, dUnd, dIgn, dDone}), 32'd0);

    // R9: status write with enable bit off
    setReq(1, 4'b0001, 4'd2, 32'hDEAD_BEEF, 2'd1, 1, 1, 0); issue("R9");
    // R11: exception-control write with enable off still lands
    setReq(1, 4'b1000, 4'd3, 32'h4000_0001, 2'd1, 1, 1, 0); issue("R11");
    // R10: status write at user level now enabled
    setReq(1, 4'b0001, 4'd0, 32'h1234_5678, 2'd0, 1, 1, 0); issue("R10");
    // R12: privileged id write ignored
    setReq(1, 4'b0000, 4'd1, 32'hFFFF_FFFF, 2'd2, 1, 1, 0); issue("R12");
    // R3: cond fail over a writable target
    setReq(0, 4'b1000, 4'd1, 32'h0, 2'd1, 1, 1, 0); issue("R3");
    // R4: bad index with reserved selector
    setReq(1, 4'b0110, 4'd15, 32'h55, 2'd1, 1, 1, 0); issue("R4");
    // R5: reserved selectors in both variants
    setReq(1, 4'b1001, 4'd4, 32'h66, 2'd1, 1, 1, 1); issue("R5");
    setReq(1, 4'b1111, 4'd4, 32'h66, 2'd0, 0, 0, 0); issue("R5");
    // R6: user write to exception-control beats hyp trap
    setReq(1, 4'b1000, 4'd5, 32'h0, 2'd0, 1, 1, 1); issue("R6");
    // R7: hyp trap beats coarse denial
    setReq(1, 4'b0001, 4'd5, 32'h7, 2'd1, 0, 1, 1); issue("R7");
    // R8: secure denial
    setReq(1, 4'b1000, 4'd5, 32'h0, 2'd1, 1, 0, 0); issue("R8");
    // R11: clear enable bit via exception-control write
    setReq(1, 4'b1000, 4'd6, 32'h0000_00FF, 2'd3, 1, 1, 0); issue("R11");
    // R2: idle cycles give no response
    repeat (2) @(negedge clk);
    check("R2 idle", 32'({dHyp, dUnd, dIgn, dDone, nHyp, nUnd, nIgn, nDone}), 32'd0);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] s;
      case ($urandom % 4)
        0: s = 4'b0000; 1: s = 4'b0001; 2: s = 4'b1000; default: s = 4'($urandom);
      endcase
      setReq(($urandom % 8) != 0, s, (($urandom % 8) == 0) ? 4'd15 : 4'($urandom % 15),
             $urandom, 2'($urandom), ($urandom % 6) != 0, ($urandom % 6) != 0,
             ($urandom % 6) == 0);
      issue("R2 random");
      if (($urandom % 4) == 0) @(negedge clk);
    end
    finish_run();
  end
endmodule